// File: doc/BRIEF.md
# Multi-Mode CAN Event Counter

This block is a single 15-bit counter for a CAN node, shared by four counting modes. Software picks the mode. Frame mode counts completed received and/or transmitted frames. Timestamp mode counts bit times. Interval mode measures the clock cycles between consecutive bit-timing events. Error mode counts detected errors and received error frames. The event strobes come from the protocol engine and are one clock wide.

Software can write the count at any time. When the count wraps, a sticky overflow flag is set and stays set until software clears it. A one-cycle interrupt request goes with the wrap only if the overflow interrupt enable is set. Routing that request to an interrupt line is the job of the logic around this block.

Top module: `can_event_counter`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the overflow flag is 0 and the interrupt request is 0. The configuration is: frame mode, selection 00, interrupt enable 0.
- R2: A counter write loads `cnt_wdata_i` into the count at the next clock edge. The write wins over any increment or measurement load in the same cycle.
- R3: Frame mode (mode 00) adds one for each cycle in which a selected frame strobe is high. Selection 01 counts received frames only. Selection 10 counts transmitted frames only. Selections 00 and 11 count both kinds. A cycle with both strobes high adds exactly one.
- R4: Timestamp mode (mode 01) adds one per `bit_tick_i` pulse. Frame, sync and error strobes leave the count unchanged.
- R5: Error mode (mode 11) adds one per `err_evt_i` pulse. Other strobes leave the count unchanged.
- R6: Interval mode (mode 10) loads the count at each `sync_evt_i` with the number of clock cycles since the previous sync event, saturating at the maximum. A configuration write or leaving the mode restarts the measurement from zero. Loads never set the overflow flag.
- R7: An increment from 0x7FFF gives 0x0000. The overflow flag is set at that same clock edge.
- R8: The overflow flag stays set until a cycle with `ovf_clr_i` high. If a wrap and a clear happen in the same cycle, the flag ends up set.
- R9: `irq_o` is high for exactly the one cycle in which the flag first shows a wrap, and only if the interrupt enable was 1 when the wrap happened.
- R10: A configuration write takes effect from the following cycle. The strobes in the cycle of the write are judged under the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done_i | input | 1 | Frame received strobe |
| tx_done_i | input | 1 | Frame transmitted strobe |
| bit_tick_i | input | 1 | One bit time elapsed strobe |
| sync_evt_i | input | 1 | Bit-timing analysis event strobe |
| err_evt_i | input | 1 | Error detected or error frame received strobe |
| cfg_we_i | input | 1 | Write mode, selection and interrupt enable |
| cfg_mode_i | input | 2 | Mode: 00 frame, 01 timestamp, 10 interval, 11 error |
| cfg_sel_i | input | 2 | Frame selection: 01 rx, 10 tx, 00/11 both |
| cfg_irq_en_i | input | 1 | Overflow interrupt enable |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 15 | Counter write value |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| count_o | output | 15 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
Some properties are checked on every cycle by the assertions. These are: write priority, wrap to zero together with the flag, the flag staying set without a clear, the one-shot and gating of the request, a held count when there is no event, stray strobes in timestamp mode, saturation of the interval timer, and the rule that measurement loads never raise the flag.

Other behaviour only shows up in the bench's scenarios, which check it against an independent reference model. This covers the frame-selection encodings, counting in each mode, the exact interval values loaded, a set and a clear in the same cycle, and configuration changes taking effect one cycle late.

// File: rtl/can_evtcnt_pkg.sv
// Shared types for the multi-mode CAN event counter.
// Assumes: the mode encoding below is the software-visible field value.
package can_evtcnt_pkg;

    typedef enum logic [1:0] {
        MODE_FRAME  = 2'b00,
        MODE_STAMP  = 2'b01,
        MODE_TIMING = 2'b10,
        MODE_ERROR  = 2'b11
    } cnt_mode_e;

    // Frame selection encodings
    localparam logic [1:0] SEL_RX_ONLY = 2'b01;
    localparam logic [1:0] SEL_TX_ONLY = 2'b10;

endpackage

// File: rtl/evt_select.sv
// Event selector: turns the raw strobes into one increment request or one
// measurement-load request, according to the active mode.
// Assumes: strobes are one-cycle pulses synchronous to clk.
module evt_select
    import can_evtcnt_pkg::*;
(
    input  cnt_mode_e  mode_i,
    input  logic [1:0] sel_i,
    input  logic       rx_i,
    input  logic       tx_i,
    input  logic       tick_i,
    input  logic       sync_i,
    input  logic       err_i,
    output logic       inc_o,
    output logic       meas_o
);

    logic rx_ok;
    logic tx_ok;

    // Frame-kind gating from the selection field
    always_comb begin
        rx_ok = rx_i && (sel_i != SEL_TX_ONLY);
        tx_ok = tx_i && (sel_i != SEL_RX_ONLY);
    end

    // Mode decode: at most one of inc_o / meas_o can be high
    always_comb begin
        inc_o  = 1'b0;
        meas_o = 1'b0;
        unique case (mode_i)
            MODE_FRAME:  inc_o  = rx_ok || tx_ok;
            MODE_STAMP:  inc_o  = tick_i;
            MODE_TIMING: meas_o = sync_i;
            MODE_ERROR:  inc_o  = err_i;
        endcase
    end

endmodule

// File: rtl/interval_timer.sv
// Interval timer: counts clock cycles since the last sync event, saturating
// at the maximum. A sync event restarts it at 1. restart_i forces it to 0.
// Assumes: the caller samples run_o in the cycle of the sync event.
module interval_timer #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         evt_i,
    output logic [W-1:0] run_o
);

    localparam logic [W-1:0] RUN_MAX = '1;
    localparam logic [W-1:0] RUN_ONE = W'(1);

    logic [W-1:0] run_q;

    // Running cycle count with restart and saturation
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            run_q <= '0;
        end else if (evt_i) begin
            run_q <= RUN_ONE;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + RUN_ONE;
        end
    end

    assign run_o = run_q;

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_MAX && !evt_i && !restart_i) |=> (run_q == RUN_MAX)); // R6

endmodule

// File: rtl/count_core.sv
// Count core: holds the count, the sticky overflow flag and the interrupt
// pulse. Priority: software write, then measurement load, then increment.
// Assumes: load_i and inc_i are never high together.
module count_core #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         ie_i,
    output logic [W-1:0] count_o,
    output logic         ovf_o,
    output logic         irq_o
);

    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic [W-1:0] count_q;
    logic         ovf_q;
    logic         irq_q;
    logic         wrap;

    // Wrap happens only on an increment that is not overridden
    always_comb wrap = inc_i && !we_i && !load_i && (&count_q);

    // Count register update with write priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (we_i) begin
            count_q <= wdata_i;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (inc_i) begin
            count_q <= count_q + CNT_ONE;
        end
    end

    // Sticky flag (set wins over clear) and gated one-shot request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            ovf_q <= wrap || (ovf_q && !clr_i);
            irq_q <= wrap && ie_i;
        end
    end

    assign count_o = count_q;
    assign ovf_o   = ovf_q;
    assign irq_o   = irq_q;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (count_q == $past(wdata_i))); // R2
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !we_i && !load_i && count_q == '1) |=> (count_q == '0 && ovf_q)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q); // R8
    AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(ie_i) && ovf_q)); // R9
    AST_MEASURE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ovf_q) |=> !ovf_q); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !load_i && !inc_i) |=> $stable(count_q)); // R4

endmodule

// File: rtl/can_event_counter.sv
// Multi-mode CAN event counter top. Holds the configuration registers and
// connects the event selector, the interval timer and the count core.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module can_event_counter
    import can_evtcnt_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_done_i,
    input  logic             tx_done_i,
    input  logic             bit_tick_i,
    input  logic             sync_evt_i,
    input  logic             err_evt_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic             cfg_irq_en_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);

    cnt_mode_e        mode_q;
    logic [1:0]       sel_q;
    logic             ie_q;
    logic             inc;
    logic             meas;
    logic             restart;
    logic [CNT_W-1:0] run_val;

    // Configuration registers, effective from the cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FRAME;
            sel_q  <= 2'b00;
            ie_q   <= 1'b0;
        end else if (cfg_we_i) begin
            mode_q <= cnt_mode_e'(cfg_mode_i);
            sel_q  <= cfg_sel_i;
            ie_q   <= cfg_irq_en_i;
        end
    end

    // Interval measurement restarts on reconfiguration or outside its mode
    always_comb restart = cfg_we_i || (mode_q != MODE_TIMING);

    evt_select u_sel (
        .mode_i (mode_q),
        .sel_i  (sel_q),
        .rx_i   (rx_done_i),
        .tx_i   (tx_done_i),
        .tick_i (bit_tick_i),
        .sync_i (sync_evt_i),
        .err_i  (err_evt_i),
        .inc_o  (inc),
        .meas_o (meas)
    );

    interval_timer #(.W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .evt_i     (sync_evt_i),
        .run_o     (run_val)
    );

    count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cnt_we_i),
        .wdata_i    (cnt_wdata_i),
        .load_i     (meas),
        .load_val_i (run_val),
        .inc_i      (inc),
        .clr_i      (ovf_clr_i),
        .ie_i       (ie_q),
        .count_o    (count_o),
        .ovf_o      (ovf_o),
        .irq_o      (irq_o)
    );

    AST_STAMP_IGNORES_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STAMP && !bit_tick_i && !cnt_we_i) |=> $stable(count_o)); // R4
    AST_ERROR_IGNORES_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ERROR && !err_evt_i && !cnt_we_i) |=> $stable(count_o)); // R5

endmodule

// File: tb/can_event_counter_tb.sv
// Scoreboard bench: the driver task applies one vector per cycle and pushes
// the model's expected outputs; the monitor pops and compares after each edge.
module can_event_counter_tb;

    localparam int W = 15;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 0, tx = 0, bt = 0, se = 0, er = 0;
    logic cfg_we = 0, cfg_ie = 0, cnt_we = 0, clr = 0;
    logic [1:0] cfg_mode = 0, cfg_sel = 0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] count;
    logic ovf, irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    logic [W-1:0] m_cnt = '0, m_run = '0;
    logic m_ovf = 0, m_irq = 0, m_ie = 0;
    logic [1:0] m_mode = 0, m_sel = 0;

    logic [W+1:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    can_event_counter #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_done_i(rx), .tx_done_i(tx), .bit_tick_i(bt), .sync_evt_i(se), .err_evt_i(er),
        .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_sel_i(cfg_sel), .cfg_irq_en_i(cfg_ie),
        .cnt_we_i(cnt_we), .cnt_wdata_i(wdata), .ovf_clr_i(clr),
        .count_o(count), .ovf_o(ovf), .irq_o(irq)
    );

    // Driver: one vector per cycle plus model update and expectation push
    task automatic step(input logic i_rx, i_tx, i_bt, i_se, i_er,
                        input logic i_cwe, input logic [W-1:0] i_wd, input logic i_clr,
                        input logic i_cfg, input logic [1:0] i_md, i_sl, input logic i_ie,
                        input string tag);
        logic inc, wrap;
        @(negedge clk);
        rx = i_rx; tx = i_tx; bt = i_bt; se = i_se; er = i_er;
        cnt_we = i_cwe; wdata = i_wd; clr = i_clr;
        cfg_we = i_cfg; cfg_mode = i_md; cfg_sel = i_sl; cfg_ie = i_ie;
        case (m_mode)
            2'b00:   inc = (i_rx && m_sel != 2'b10) || (i_tx && m_sel != 2'b01);
            2'b01:   inc = i_bt;
            2'b11:   inc = i_er;
            default: inc = 1'b0;
        endcase
        wrap = 1'b0;
        if (i_cwe) m_cnt = i_wd;
        else if (m_mode == 2'b10 && i_se) m_cnt = m_run;
        else if (inc) begin wrap = (m_cnt == MAXV); m_cnt = m_cnt + 1'b1; end
        m_ovf = wrap ? 1'b1 : (i_clr ? 1'b0 : m_ovf);
        m_irq = wrap && m_ie;
        if (i_cfg || m_mode != 2'b10) m_run = '0;
        else if (i_se) m_run = 1;
        else if (m_run != MAXV) m_run = m_run + 1'b1;
        if (i_cfg) begin m_mode = i_md; m_sel = i_sl; m_ie = i_ie; end
        exp_q.push_back({m_cnt, m_ovf, m_irq});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0, 0,'0,0, 0,2'b00,2'b00,0, tag);
    endtask
    task automatic strobe(input logic i_rx, i_tx, i_bt, i_se, i_er, input string tag);
        step(i_rx,i_tx,i_bt,i_se,i_er, 0,'0,0, 0,2'b00,2'b00,0, tag);
    endtask
    task automatic wr(input logic [W-1:0] v, input string tag);
        step(1,1,1,1,1, 1,v,0, 0,2'b00,2'b00,0, tag);
    endtask
    task automatic cfg(input logic [1:0] md, sl, input logic ie, input string tag);
        step(0,0,0,0,0, 0,'0,0, 1,md,sl,ie, tag);
    endtask

    // Monitor: compare after each rising edge, away from the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [W+1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if ({count, ovf, irq} !== e) begin
                fails++;
                $display("FAIL %s: got cnt=%h ovf=%b irq=%b, expected cnt=%h ovf=%b irq=%b",
                         t, count, ovf, irq, e[W+1:2], e[1], e[0]);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // R3 frame mode, selection 00 counts both kinds
        strobe(1,0,0,0,0, "R3 rx sel00");
        strobe(0,1,0,0,0, "R3 tx sel00");
        strobe(1,1,0,0,0, "R3 both once");
        strobe(0,0,1,1,1, "R3 foreign strobes");
        cfg(2'b00, 2'b01, 0, "R10 cfg rx-only");
        strobe(0,1,0,0,0, "R3 tx ignored rx-only");
        strobe(1,0,0,0,0, "R3 rx counted rx-only");
        cfg(2'b00, 2'b10, 0, "R10 cfg tx-only");
        strobe(1,0,0,0,0, "R3 rx ignored tx-only");
        strobe(0,1,0,0,0, "R3 tx counted tx-only");
        cfg(2'b00, 2'b11, 0, "R10 cfg both");
        strobe(1,0,0,0,0, "R3 rx sel11");
        // R2 write wins over strobes
        wr(15'h0100, "R2 write priority");
        // R10 old mode still applies in cfg cycle
        step(1,0,1,0,0, 0,'0,0, 1,2'b01,2'b00,0, "R10 old mode in cfg cycle");
        strobe(0,0,1,0,0, "R4 tick");
        strobe(1,1,0,1,1, "R4 others ignored");
        strobe(0,0,1,0,0, "R4 tick again");
        // R5 error mode
        cfg(2'b11, 2'b00, 0, "R10 cfg error");
        strobe(0,0,0,0,1, "R5 error");
        strobe(1,1,1,1,0, "R5 others ignored");
        strobe(0,0,0,0,1, "R5 error again");
        // R7 R8 R9 wrap with enable
        cfg(2'b01, 2'b00, 1, "R10 cfg stamp ie");
        wr(15'h7FFE, "R2 preload");
        strobe(0,0,1,0,0, "R7 to max");
        strobe(0,0,1,0,0, "R7 wrap irq R9");
        idle("R9 pulse ends");
        idle("R8 flag sticky");
        step(0,0,0,0,0, 0,'0,1, 0,2'b00,2'b00,0, "R8 clear");
        wr(15'h7FFF, "R2 preload max");
        step(0,0,1,0,0, 0,'0,1, 0,2'b00,2'b00,0, "R8 set beats clear");
        step(0,0,0,0,0, 0,'0,1, 1,2'b01,2'b00,0, "R8 clear again");
        wr(15'h7FFF, "R2 preload max ie0");
        strobe(0,0,1,0,0, "R9 no irq when disabled");
        // R6 interval mode
        cfg(2'b10, 2'b00, 1, "R10 cfg timing");
        strobe(0,0,0,1,0, "R6 first sync");
        idle("R6 hold");
        idle("R6 hold");
        idle("R6 hold");
        strobe(0,0,0,1,0, "R6 interval 4");
        strobe(1,1,1,0,1, "R6 foreign ignored");
        strobe(0,0,0,1,0, "R6 interval 2");
        strobe(0,0,0,1,0, "R6 interval 1");
        wr(15'h7FFF, "R2 write in timing");
        strobe(0,0,0,1,0, "R6 no flag on load");
        idle("R6 final");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule